// File: doc/BRIEF.md
# Microcontroller firmware download port

This block is a single 32-bit control/status register through which a host loads program bytes into the code RAM of an embedded microcontroller. The same register then streams those bytes back so the host can check them. The top byte of every written word is a control code. One code selects upload mode, which holds the core in reset. A second code marks the end of the upload, and a third releases the core to run.

In upload mode a write carries a data byte and a target address. The byte goes to the code RAM through a byte-wide write port. Only the low address byte comes from the host; the upper address bits are taken from the internal pointer. Each read in upload mode returns the control byte, the RAM byte at the pointer and the pointer itself, then advances the pointer by one. The host loads a byte, reads it back and compares the result with what it wrote, so the pointer moves on in step with the loading. Outside upload mode a read returns the control byte and the stored size field, and the pointer stays where it is.

The code RAM sits outside the block. The block drives its write port and its read address, and takes the read data back combinationally.

Top module: `fw_download_port`

## Requirements
- R1: After reset, `core_hold` is 1, `rdata` reads 0x00000000, and `ram_we` is 0 while no write is made.
- R2: A write whose bits [31:24] equal 0x0F raises `ram_we` in that cycle. `ram_wdata` is bits [23:16] of the word. `ram_waddr` is the pointer's bits above bit 7 joined to bits [7:0] of the word. No other write touches the RAM.
- R3: While the stored control byte is 0x0F, `rdata` is {control byte, RAM byte at pointer, zero padding, pointer}. A read without a write in the same cycle advances the pointer by one, wrapping from the last address to 0.
- R4: An upload write loads the pointer with the address of R2. Bits [15:8] of the written word have no effect on the pointer or on the RAM address.
- R5: Writing an upload word whose address lies within the pointer's current 256-byte page and then reading returns exactly the written word, with bits [15:ADDR_W] of the word at zero.
- R6: A write with code 0x03 stores 0x03 as the control byte and bits [15:0] as the size. Reads then return {0x03, 0x00, size} without moving the pointer, and `core_hold` keeps its value.
- R7: A write with code 0x13 stores the size, drops `core_hold` to 0 from the next cycle, and reads return {0x13, 0x00, size}.
- R8: An upload write sets `core_hold` to 1 from the next cycle, whatever its previous value.
- R9: When a write and a read arrive in the same cycle, the write takes effect and the read does not advance the pointer.
- R10: A write with any code other than 0x0F or 0x13 stores the code and the size, does not write the RAM, and leaves `core_hold` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, advances the pointer in upload mode |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data |
| ram_we | output | 1 | Code RAM write enable |
| ram_waddr | output | ADDR_W | Code RAM write address |
| ram_wdata | output | 8 | Code RAM write byte |
| ram_raddr | output | ADDR_W | Code RAM read address (the pointer) |
| ram_rdata | input | 8 | Code RAM read byte, combinational |
| core_hold | output | 1 | Holds the microcontroller in reset while 1 |

## Verification
The bench builds the block with ADDR_W = 10, a 1024-byte code RAM. With that size, a stream of reads reaches the wrap from 0x3FF to 0 in about a thousand cycles. It still leaves two address bits above the host-writable byte, so loading 300 bytes crosses a page boundary. That exercises upper pointer bits being kept while the host only supplies the low byte. The width of the zero padding in read data also differs from the default, which checks that the padding follows the parameter.

// File: rtl/fw_download_port.sv
module fw_download_port #(
  parameter int ADDR_W = 14,
  parameter logic [7:0] CODE_LOAD = 8'h0F,
  parameter logic [7:0] CODE_DONE = 8'h03,
  parameter logic [7:0] CODE_RUN  = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic              core_hold
);
  localparam int PAD_W = 16 - ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [7:0]        ctrl_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [15:0]       size_q;
  logic              hold_q;

  logic [7:0]        wr_code;
  logic              load_wr;
  logic              uploading;
  logic [ADDR_W-1:0] wr_addr;

  assign wr_code   = wdata[31:24];
  assign load_wr   = wr_en && (wr_code == CODE_LOAD);
  assign uploading = (ctrl_q == CODE_LOAD);
  assign wr_addr   = {ptr_q[ADDR_W-1:8], wdata[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 8'h00;
      ptr_q  <= '0;
      size_q <= 16'h0000;
      hold_q <= 1'b1;
    end else if (wr_en) begin
      ctrl_q <= wr_code;
      if (load_wr) begin
        ptr_q  <= wr_addr;
        hold_q <= 1'b1;
      end else begin
        size_q <= wdata[15:0];
        if (wr_code == CODE_RUN) hold_q <= 1'b0;
      end
    end else if (rd_en && uploading) begin
      ptr_q <= ptr_q + ONE;
    end
  end

  assign ram_we    = load_wr;
  assign ram_waddr = wr_addr;
  assign ram_wdata = wdata[23:16];
  assign ram_raddr = ptr_q;
  assign core_hold = hold_q;

  assign rdata = uploading ? {ctrl_q, ram_rdata, {PAD_W{1'b0}}, ptr_q}
                           : {ctrl_q, 8'h00, size_q};
endmodule

module fw_download_port_chk #(
  parameter int ADDR_W = 14,
  parameter logic [7:0] CODE_LOAD = 8'h0F,
  parameter logic [7:0] CODE_RUN  = 8'h13
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wr_code,
  input logic [7:0]  wr_lo,
  input logic [7:0]  rd_ctrl,
  input logic [15:0] rd_low,
  input logic        core_hold
);
  p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_en && rd_ctrl == CODE_LOAD) |=>
      (rd_low[ADDR_W-1:0] == ADDR_W'($past(rd_low[ADDR_W-1:0]) + 1'b1)));

  p_load_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == CODE_LOAD) |=>
      (rd_low[7:0] == $past(wr_lo) && rd_ctrl == CODE_LOAD));

  p_static_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_ctrl != CODE_LOAD) |=> ($stable(rd_low) && $stable(rd_ctrl)));

  p_run_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == CODE_RUN) |=> !core_hold);

  p_load_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == CODE_LOAD) |=> core_hold);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(core_hold));
endmodule

bind fw_download_port fw_download_port_chk #(
  .ADDR_W(ADDR_W), .CODE_LOAD(CODE_LOAD), .CODE_RUN(CODE_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .wr_code(wdata[31:24]), .wr_lo(wdata[7:0]),
  .rd_ctrl(rdata[31:24]), .rd_low(rdata[15:0]), .core_hold(core_hold)
);

// File: tb/fw_download_port_bench.sv
module fw_download_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0] ram_wdata, ram_rdata;
  logic core_hold;

  logic [7:0] ram [0:DEPTH-1];
  logic [7:0] m_mem [0:DEPTH-1];
  int m_ctrl = 0, m_ptr = 0, m_size = 0, m_hold = 1;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_download_port #(.ADDR_W(AW)) u_fw_download_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata), .core_hold(core_hold)
  );

  initial for (int i = 0; i < DEPTH; i++) begin ram[i] = 8'h00; m_mem[i] = 8'h00; end
  always @(posedge clk) if (ram_we) ram[ram_waddr] <= ram_wdata;
  assign ram_rdata = ram[ram_raddr];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rdata();
    if (m_ctrl == 8'h0F) return {8'(m_ctrl), m_mem[m_ptr], 16'(m_ptr)};
    return {8'(m_ctrl), 8'h00, 16'(m_size)};
  endfunction

  // reference model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ptr = 0; m_size = 0; m_hold = 1;
    end else if (wr_en) begin
      m_ctrl = int'(wdata[31:24]);
      if (wdata[31:24] == 8'h0F) begin
        m_ptr = (m_ptr / 256) * 256 + int'(wdata[7:0]);
        m_mem[m_ptr] = wdata[23:16];
        m_hold = 1;
      end else begin
        m_size = int'(wdata[15:0]);
        if (wdata[31:24] == 8'h13) m_hold = 0;
      end
    end else if (rd_en && m_ctrl == 8'h0F) begin
      m_ptr = (m_ptr + 1) % DEPTH;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    check(rdata == model_rdata(), "R3 rdata", rdata, model_rdata());
    check(core_hold == 1'(m_hold), "R7 core_hold", 32'(core_hold), 32'(m_hold));
    check(ram_we == (wr_en && wdata[31:24] == 8'h0F), "R2 ram_we", 32'(ram_we),
          32'(wr_en && wdata[31:24] == 8'h0F));
    if (ram_we) begin
      check(ram_waddr == AW'((m_ptr / 256) * 256 + int'(wdata[7:0])), "R2 ram_waddr",
            32'(ram_waddr), 32'((m_ptr / 256) * 256 + int'(wdata[7:0])));
      check(ram_wdata == wdata[23:16], "R2 ram_wdata", 32'(ram_wdata), 32'(wdata[23:16]));
    end
  end

  task automatic cyc(input bit w, input bit r, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    wr_en = w; rd_en = r; wdata = d;
    #(CLK_PERIOD/4 + 1);
    q = rdata;
  endtask

  task automatic host_write(input logic [31:0] d);
    logic [31:0] q;
    cyc(1'b1, 1'b0, d, q);
  endtask

  task automatic host_read(output logic [31:0] q);
    cyc(1'b0, 1'b1, 32'h0, q);
  endtask

  task automatic idle();
    logic [31:0] q;
    cyc(1'b0, 1'b0, 32'h0, q);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q, w, prev;
    repeat (3) idle();
    check(rdata == 32'h0, "R1 reset rdata", rdata, 32'h0);
    check(core_hold == 1'b1, "R1 reset hold", 32'(core_hold), 32'h1);
    rst_n = 1'b1;
    idle();
    host_read(q);
    host_read(q);
    check(q == 32'h0, "R1 read before upload", q, 32'h0);

    host_write(32'h0F000000);
    check(core_hold == 1'b1, "R8 upload hold", 32'(core_hold), 32'h1);
    for (int a = 0; a < 300; a++) begin
      w = {8'h0F, 8'((a * 37 + 11) & 8'hFF), 16'(a)};
      host_write(w);
      host_read(q);
      check(q == w, "R5 readback", q, w);
    end

    // pointer now 300 (page 1); upper written bits ignored
    host_write(32'h0FAB3A40);
    host_read(q);
    check(q == 32'h0FAB0140, "R4 upper bits ignored", q, 32'h0FAB0140);

    // same-cycle write and read
    cyc(1'b1, 1'b1, 32'h0F5C0177, q);
    host_read(q);
    check(q == 32'h0F5C0177, "R9 write wins over read", q, 32'h0F5C0177);

    // stream across the wrap
    host_read(prev);
    for (int k = 0; k < 1100; k++) begin
      host_read(q);
      if (prev[15:0] == 16'(DEPTH - 1))
        check(q[15:0] == 16'h0, "R3 pointer wrap", 32'(q[15:0]), 32'h0);
      else
        check(q[15:0] == prev[15:0] + 16'h1, "R3 pointer step", 32'(q[15:0]),
              32'(prev[15:0] + 16'h1));
      prev = q;
    end

    host_write(32'h0300012C);
    host_read(q);
    host_read(q);
    check(q == 32'h0300012C, "R6 done readback", q, 32'h0300012C);
    check(core_hold == 1'b1, "R6 hold kept", 32'(core_hold), 32'h1);

    host_write(32'h55DD1234);
    idle();
    check(rdata == 32'h55001234, "R10 other code", rdata, 32'h55001234);
    check(core_hold == 1'b1, "R10 hold unchanged", 32'(core_hold), 32'h1);
    check(ram[8'h34] == m_mem[8'h34], "R10 ram untouched", 32'(ram[8'h34]), 32'(m_mem[8'h34]));

    host_write(32'h1300012C);
    idle();
    check(core_hold == 1'b0, "R7 run release", 32'(core_hold), 32'h0);
    check(rdata == 32'h1300012C, "R7 run readback", rdata, 32'h1300012C);

    host_write(32'h42000000);
    idle();
    check(core_hold == 1'b0, "R10 hold stays released", 32'(core_hold), 32'h0);

    host_write(32'h0F000000);
    idle();
    check(core_hold == 1'b1, "R8 hold reasserted", 32'(core_hold), 32'h1);
    repeat (2) idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule